// File: doc/BRIEF.md
# PLL Retune Sequencer

This block is a small state machine that changes the operating point of a clock-generating PLL without leaving the downstream logic on an unsafe clock. A full retune request carries a multiplier, a pre-divider and an output post-divider. The sequencer first puts the PLL in bypass and waits until the PLL reports that it is in bypass and no longer locked. It then writes the multiplier and pre-divider, writes the post-divider, and asks the PLL to lock again. It finishes once the PLL reports lock and has left bypass. For example, the PLL can run its oscillator at 1200 MHz with a post-divider that gives a 600 MHz output.

A second kind of request changes only the post-divider. The PLL stays locked. The change counts as accepted when the PLL's acknowledge bit flips relative to its value at the moment of the write. The flip may go in either direction.

Every wait has a programmable cycle timeout. On expiry the sequencer raises a sticky error, leaves the PLL in bypass and returns to idle. The three status inputs from the PLL pass through a two-stage synchronizer before the state machine uses them. A full request also loads the bypass-source select. That select chooses the main reference, which reaches the PLL through its own 1/(N2+1) divider, or an alternate low-speed clock. The switch itself is the PLL's glitch-free mux.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `pll_mode` is 3'h4 (bypass), `pll_mult`, `pll_div` and `pll_m2` are 0, and `busy`, `done`, `err_timeout` and `byp_src_sel` are 0.
- R2: A full request accepted in idle sets `pll_mode` to 3'h4 on the accepting edge. `pll_mult` and `pll_div` take the requested values only after the synchronized bypass status reads 1 and the synchronized lock status reads 0.
- R3: In a full retune, `pll_m2` is written on a later edge than `pll_mult`/`pll_div`. `pll_mode` becomes 3'h7 (lock) on an edge after the `pll_m2` write.
- R4: A full retune raises `done` for one cycle only after the synchronized lock status reads 1 and the synchronized bypass status reads 0. At that point `pll_mode` is 3'h7 and all three divider outputs hold the requested values.
- R5: A post-divider-only request writes `pll_m2` on the accepting edge and never changes `pll_mode`. It completes when the synchronized acknowledge differs from its value at the write, in either direction.
- R6: If `req_full` and `req_m2only` are both high in the same idle cycle, the full retune is performed.
- R7: `busy` is 1 from the edge after acceptance until the cycle that `done` or the error rises. `done` and `busy` are never both high. Requests that arrive while `busy` is high have no effect.
- R8: If a wait has not been satisfied after `cfg_timeout` waiting cycles, the next edge sets `err_timeout`, sets `pll_mode` to 3'h4, clears `busy` and returns to idle without `done`. For a post-divider-only request accepted at edge e0 with no acknowledge, the error appears at edge e(T+1).
- R9: `err_timeout` stays 1 until the next accepted request, which clears it on its accepting edge.
- R10: `byp_src_sel` takes `cfg_alt_src` on the edge that accepts a full request (0 = main reference, 1 = alternate low-speed input). A post-divider-only request leaves it unchanged.
- R11: Status inputs pass through two flip-flops. With acknowledge toggling at edge a, `done` of a post-divider-only request rises at edge a+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_full | input | 1 | Start a full bypass/reprogram/relock retune |
| req_m2only | input | 1 | Start a post-divider-only change |
| cfg_mult | input | MULT_W | Requested multiplier |
| cfg_div | input | DIV_W | Requested pre-divider |
| cfg_m2 | input | M2_W | Requested post-divider |
| cfg_alt_src | input | 1 | Requested bypass source (1 = alternate) |
| cfg_timeout | input | TO_W | Wait timeout in cycles |
| st_bypass | input | 1 | PLL bypass status (asynchronous) |
| st_lock | input | 1 | PLL lock status (asynchronous) |
| m2_ack | input | 1 | PLL post-divider acknowledge, toggles (asynchronous) |
| pll_mode | output | 3 | PLL mode field: 3'h4 bypass, 3'h7 lock |
| pll_mult | output | MULT_W | Multiplier to the PLL |
| pll_div | output | DIV_W | Pre-divider to the PLL |
| pll_m2 | output | M2_W | Post-divider to the PLL |
| byp_src_sel | output | 1 | Bypass clock source select |
| busy | output | 1 | A retune is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Sticky timeout error |

## Verification
Two events can meet in the same cycle: a new request arriving while a retune is still in flight, and the completion or timeout of that retune. The bench pulses both request inputs, with other divider values, a few cycles into a full retune. It then checks that the final divider outputs and the single `done` pulse belong to the first request only. A second collision is the post-divider acknowledge flipping right after the write. The behavioural PLL model sweeps the acknowledge delay down to zero, and the bench judges each case by the exact edge on which `done` rises.

// File: rtl/pllseq_pkg.sv
// Package: shared encodings and state type for the PLL retune sequencer.
// Assumes the PLL decodes a 3-bit mode field in which 3'h4 means bypass
// and 3'h7 means lock.
package pllseq_pkg;
    localparam logic [2:0] MODE_BYPASS = 3'h4;
    localparam logic [2:0] MODE_LOCK   = 3'h7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_BYP,
        S_PROG_M2,
        S_REQ_LOCK,
        S_WAIT_LOCK,
        S_WAIT_ACK
    } seq_state_e;
endpackage

// File: rtl/pllseq_sync.sv
// Multi-stage synchronizer for level status inputs coming from the PLL
// domain. Assumes every bit is an independent, slow-changing level.
module pllseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LAST];
endmodule

// File: rtl/pllseq_timer.sv
// Down-counting wait timer. Loaded with a limit when a wait begins. It
// counts down while the owner waits, and reports expiry when it reads zero.
module pllseq_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TO_W-1:0] limit,
    input  logic            run,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    // Purpose: load the limit or count one waiting cycle down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= limit;
        else if (run && cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R8: without a load the count never goes up
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/pllseq_ackdet.sv
// Toggle detector for the post-divider acknowledge. It keeps the
// acknowledge level present at the post-divider write and flags any later
// difference. The input is assumed already synchronized.
module pllseq_ackdet (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic ack_s,
    output logic toggled
);
    logic ack_ref;

    // Purpose: hold the acknowledge level seen at the moment of the write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_ref <= 1'b0;
        else if (capture) ack_ref <= ack_s;
    end

    assign toggled = (ack_s != ack_ref);
endmodule

// File: rtl/pll_retune_seq.sv
// PLL retune sequencer. A full request runs bypass -> program mult/div ->
// program post-divider -> lock. A post-divider-only request writes the
// post-divider with the PLL locked and waits for the acknowledge toggle.
// Every wait is bounded by a timeout. On timeout the PLL is left in bypass
// and a sticky error is raised. Assumes the request inputs are synchronous
// to clk and the status inputs are not.
module pll_retune_seq
    import pllseq_pkg::*;
#(
    parameter int MULT_W      = 11,
    parameter int DIV_W       = 7,
    parameter int M2_W        = 5,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_full,
    input  logic              req_m2only,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [M2_W-1:0]   cfg_m2,
    input  logic              cfg_alt_src,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              st_bypass,
    input  logic              st_lock,
    input  logic              m2_ack,
    output logic [2:0]        pll_mode,
    output logic [MULT_W-1:0] pll_mult,
    output logic [DIV_W-1:0]  pll_div,
    output logic [M2_W-1:0]   pll_m2,
    output logic              byp_src_sel,
    output logic              busy,
    output logic              done,
    output logic              err_timeout
);
    localparam int ST_W = 3;

    seq_state_e        state, state_n;
    logic [ST_W-1:0]   st_sync;
    logic              byp_s, lock_s, ack_s;
    logic [MULT_W-1:0] sh_mult;
    logic [DIV_W-1:0]  sh_div;
    logic [M2_W-1:0]   sh_m2;
    logic [TO_W-1:0]   sh_to;
    logic [TO_W-1:0]   tmr_limit;
    logic              accept_full, accept_m2;
    logic              byp_ok, lock_ok, ack_tog;
    logic              waiting, cond_met, expired;
    logic              tmr_load, finish_ok, timeout_hit;

    pllseq_sync #(.WIDTH(ST_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({m2_ack, st_lock, st_bypass}),
        .dout (st_sync)
    );
    assign {ack_s, lock_s, byp_s} = st_sync;

    assign accept_full = (state == S_IDLE) && req_full;
    assign accept_m2   = (state == S_IDLE) && !req_full && req_m2only;
    assign byp_ok      = byp_s && !lock_s;
    assign lock_ok     = lock_s && !byp_s;

    pllseq_ackdet u_ackdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(accept_m2),
        .ack_s  (ack_s),
        .toggled(ack_tog)
    );

    // Purpose: decode which wait is active and whether it is satisfied.
    always_comb begin
        waiting  = 1'b0;
        cond_met = 1'b0;
        case (state)
            S_WAIT_BYP:  begin waiting = 1'b1; cond_met = byp_ok;  end
            S_WAIT_LOCK: begin waiting = 1'b1; cond_met = lock_ok; end
            S_WAIT_ACK:  begin waiting = 1'b1; cond_met = ack_tog; end
            default:     ;
        endcase
    end

    assign tmr_load    = accept_full || accept_m2 || (state == S_REQ_LOCK);
    assign tmr_limit   = (state == S_IDLE) ? cfg_timeout : sh_to;
    assign timeout_hit = waiting && !cond_met && expired;
    assign finish_ok   = cond_met && (state == S_WAIT_LOCK || state == S_WAIT_ACK);

    pllseq_timer #(.TO_W(TO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .limit  (tmr_limit),
        .run    (waiting),
        .expired(expired)
    );

    // Purpose: next-state selection for the retune sequence.
    always_comb begin
        state_n = state;
        case (state)
            S_IDLE: begin
                if (req_full)        state_n = S_WAIT_BYP;
                else if (req_m2only) state_n = S_WAIT_ACK;
            end
            S_WAIT_BYP: begin
                if (byp_ok)       state_n = S_PROG_M2;
                else if (expired) state_n = S_IDLE;
            end
            S_PROG_M2:  state_n = S_REQ_LOCK;
            S_REQ_LOCK: state_n = S_WAIT_LOCK;
            S_WAIT_LOCK, S_WAIT_ACK: begin
                if (cond_met || expired) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Purpose: state register, request capture and PLL field writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            pll_mode    <= MODE_BYPASS;
            pll_mult    <= '0;
            pll_div     <= '0;
            pll_m2      <= '0;
            sh_mult     <= '0;
            sh_div      <= '0;
            sh_m2       <= '0;
            sh_to       <= '0;
            byp_src_sel <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            state <= state_n;
            done  <= 1'b0;
            if (accept_full) begin
                sh_mult     <= cfg_mult;
                sh_div      <= cfg_div;
                sh_m2       <= cfg_m2;
                sh_to       <= cfg_timeout;
                byp_src_sel <= cfg_alt_src;
                pll_mode    <= MODE_BYPASS;
                busy        <= 1'b1;
                err_timeout <= 1'b0;
            end
            if (accept_m2) begin
                pll_m2      <= cfg_m2;
                busy        <= 1'b1;
                err_timeout <= 1'b0;
            end
            if (state == S_WAIT_BYP && byp_ok) begin
                pll_mult <= sh_mult;
                pll_div  <= sh_div;
            end
            if (state == S_PROG_M2)  pll_m2   <= sh_m2;
            if (state == S_REQ_LOCK) pll_mode <= MODE_LOCK;
            if (finish_ok) begin
                done <= 1'b1;
                busy <= 1'b0;
            end
            if (timeout_hit) begin
                err_timeout <= 1'b1;
                busy        <= 1'b0;
                pll_mode    <= MODE_BYPASS;
            end
        end
    end

    // R2
    mn_in_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mult != $past(pll_mult) || pll_div != $past(pll_div)) |->
            (pll_mode == MODE_BYPASS && $past(byp_s) && !$past(lock_s)));

    // R3
    lock_after_m2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mode == MODE_LOCK && $past(pll_mode) != MODE_LOCK) |->
            ($past(pll_mode) == MODE_BYPASS && pll_m2 == $past(pll_m2)));

    // R5
    m2only_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ACK && $past(state) == S_WAIT_ACK) |->
            (pll_mode == $past(pll_mode)));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    timeout_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (pll_mode == MODE_BYPASS && !busy && !done));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !req_full && !req_m2only) |=> err_timeout);
endmodule

// File: tb/pll_retune_seq_tb.sv
`timescale 1ns/1ps
module pll_retune_seq_tb;
    localparam int MULT_W = 11;
    localparam int DIV_W  = 7;
    localparam int M2_W   = 5;
    localparam int TO_W   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_full = 1'b0, req_m2only = 1'b0;
    logic [MULT_W-1:0] cfg_mult = '0;
    logic [DIV_W-1:0]  cfg_div = '0;
    logic [M2_W-1:0]   cfg_m2 = '0;
    logic              cfg_alt_src = 1'b0;
    logic [TO_W-1:0]   cfg_timeout = '0;
    logic st_bypass, st_lock, m2_ack;
    logic [2:0]        pll_mode;
    logic [MULT_W-1:0] pll_mult;
    logic [DIV_W-1:0]  pll_div;
    logic [M2_W-1:0]   pll_m2;
    logic byp_src_sel, busy, done, err_timeout;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_retune_seq #(.MULT_W(MULT_W), .DIV_W(DIV_W), .M2_W(M2_W), .TO_W(TO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_full(req_full), .req_m2only(req_m2only),
        .cfg_mult(cfg_mult), .cfg_div(cfg_div), .cfg_m2(cfg_m2),
        .cfg_alt_src(cfg_alt_src), .cfg_timeout(cfg_timeout),
        .st_bypass(st_bypass), .st_lock(st_lock), .m2_ack(m2_ack),
        .pll_mode(pll_mode), .pll_mult(pll_mult), .pll_div(pll_div), .pll_m2(pll_m2),
        .byp_src_sel(byp_src_sel), .busy(busy), .done(done), .err_timeout(err_timeout)
    );

    // Behavioural PLL status model
    int lat_b = 1, lat_l = 1, lat_a = 0;
    logic stick_l = 1'b0, stick_a = 1'b0;
    logic [2:0] prev_mode = 3'h4;
    logic [M2_W-1:0] prev_m2 = '0;
    int mcnt = 0, acnt = 0;
    logic pend = 1'b0;
    logic byp_m = 1'b1, lock_m = 1'b0, ack_m = 1'b0;
    assign st_bypass = byp_m;
    assign st_lock   = lock_m;
    assign m2_ack    = ack_m;

    always @(posedge clk) begin
        prev_mode <= pll_mode;
        prev_m2   <= pll_m2;
        if (pll_mode != prev_mode) mcnt <= 0;
        else if (mcnt < 1000) mcnt <= mcnt + 1;
        if (pll_mode == 3'h4) begin
            lock_m <= 1'b0;
            if (mcnt >= lat_b) byp_m <= 1'b1;
        end else if (pll_mode == 3'h7) begin
            if (mcnt >= lat_l && !stick_l) begin
                lock_m <= 1'b1;
                byp_m  <= 1'b0;
            end
        end
        if (stick_a) pend <= 1'b0;
        else if (pll_m2 != prev_m2) begin
            pend <= 1'b1;
            acnt <= 0;
        end else if (pend && acnt >= lat_a) begin
            ack_m <= ~ack_m;
            pend  <= 1'b0;
        end else acnt <= acnt + 1;
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Ordering monitor for the full path, sampled away from the clock edge
    logic busy_q = 1'b0, seq_mn = 1'b0, seq_m2 = 1'b0;
    logic [MULT_W-1:0] mult_q = '0;
    logic [M2_W-1:0] m2_q = '0;
    logic [2:0] mode_q = 3'h4;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_q) begin seq_mn = 1'b0; seq_m2 = 1'b0; end
            if (pll_mult != mult_q) begin
                // R2 mult/div written only with the PLL in bypass and unlocked
                chk("R2", byp_m && !lock_m && pll_mode == 3'h4, {byp_m, lock_m}, 2);
                seq_mn = 1'b1;
            end
            if (pll_m2 != m2_q && pll_mode == 3'h4 && busy) begin
                // R3 post-divider after mult/div
                chk("R3", seq_mn, seq_mn, 1);
                seq_m2 = 1'b1;
            end
            if (pll_mode == 3'h7 && mode_q != 3'h7) begin
                // R3 lock requested only after post-divider write
                chk("R3", seq_m2 && pll_m2 == m2_q, seq_m2, 1);
            end
            if (done) begin
                // R4 done only after lock seen and bypass left
                chk("R4", lock_m && !byp_m, {lock_m, byp_m}, 2);
                chk("R7", !busy, busy, 0);
            end
        end
        busy_q = busy; mult_q = pll_mult; m2_q = pll_m2; mode_q = pll_mode;
    end

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (!(done || err_timeout) && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic start_full(input int m, input int n, input int m2, input logic alt, input int t);
        @(negedge clk);
        cfg_mult = MULT_W'(m); cfg_div = DIV_W'(n); cfg_m2 = M2_W'(m2);
        cfg_alt_src = alt; cfg_timeout = TO_W'(t);
        req_full = 1'b1;
        @(negedge clk);
        req_full = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc;
        logic sel_before;
        logic [2:0] mode_before;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", pll_mode == 3'h4, pll_mode, 4);
        chk("R1", pll_mult == 0 && pll_div == 0 && pll_m2 == 0, pll_mult, 0);
        chk("R1", !busy && !done && !err_timeout && !byp_src_sel,
            {busy, done, err_timeout, byp_src_sel}, 0);

        // Full retune sweep over values and status latencies
        for (int i = 0; i < 12; i++) begin
            int m, n, m2;
            m = 10 + 3 * i; n = i % 5; m2 = (i % 7) + 1;
            lat_b = (i % 3) + 1; lat_l = (i % 4) + 1;
            start_full(m, n, m2, logic'(i % 2), 20);
            // R2 bypass requested on acceptance, R7 busy
            chk("R2", pll_mode == 3'h4, pll_mode, 4);
            chk("R7", busy, busy, 1);
            wait_end(cyc);
            chk("R4", done && !err_timeout, {done, err_timeout}, 2);
            chk("R4", pll_mult == m && pll_div == n, pll_mult, m);
            chk("R4", pll_m2 == m2 && pll_mode == 3'h7, pll_m2, m2);
            chk("R10", byp_src_sel == logic'(i % 2), byp_src_sel, i % 2);
            idle(1);
            chk("R4", !done, done, 0);
            idle(8);
        end

        // Post-divider-only sweep: exact completion edge from ack latency
        for (int la = 0; la < 4; la++) begin
            int m2v;
            m2v = 20 + la;
            lat_a = la;
            sel_before = byp_src_sel;
            mode_before = pll_mode;
            @(negedge clk);
            cfg_m2 = M2_W'(m2v); cfg_alt_src = ~byp_src_sel; cfg_timeout = 30;
            req_m2only = 1'b1;
            @(negedge clk);
            req_m2only = 1'b0;
            chk("R5", pll_m2 == m2v, pll_m2, m2v);
            chk("R7", busy, busy, 1);
            for (int k = 1; k <= 5 + la; k++) begin
                @(negedge clk);
                if (k == 4 + la) chk("R11", !done, done, 0);
                if (k == 5 + la) chk("R11", done, done, 1);
                chk("R5", pll_mode == mode_before, pll_mode, mode_before);
            end
            chk("R10", byp_src_sel == sel_before, byp_src_sel, sel_before);
            idle(6);
        end

        // R7 requests while busy are ignored
        lat_b = 3; lat_l = 3;
        start_full(77, 2, 9, 1'b0, 20);
        @(negedge clk);
        cfg_mult = 300; cfg_m2 = 17; req_full = 1'b1; req_m2only = 1'b1;
        @(negedge clk);
        req_full = 1'b0; req_m2only = 1'b0;
        wait_end(cyc);
        chk("R7", done && pll_mult == 77 && pll_m2 == 9, pll_mult, 77);
        idle(12);
        chk("R7", !busy && pll_m2 == 9, pll_m2, 9);

        // R6 both requests at once: full retune wins
        @(negedge clk);
        cfg_mult = 123; cfg_div = 4; cfg_m2 = 3; cfg_alt_src = 1'b1; cfg_timeout = 20;
        req_full = 1'b1; req_m2only = 1'b1;
        @(negedge clk);
        req_full = 1'b0; req_m2only = 1'b0;
        chk("R6", pll_mode == 3'h4, pll_mode, 4);
        wait_end(cyc);
        chk("R6", pll_mult == 123 && pll_div == 4 && pll_m2 == 3, pll_mult, 123);
        idle(8);

        // R8 lock never arrives
        stick_l = 1'b1;
        start_full(55, 1, 2, 1'b0, 5);
        wait_end(cyc);
        chk("R8", err_timeout && !done, err_timeout, 1);
        chk("R8", pll_mode == 3'h4 && !busy, pll_mode, 4);
        stick_l = 1'b0;
        idle(20);
        chk("R9", err_timeout, err_timeout, 1);

        // R8 exact expiry edge on post-divider-only path (T = 6)
        start_full(60, 1, 4, 1'b0, 20);
        chk("R9", !err_timeout, err_timeout, 0);
        wait_end(cyc);
        idle(8);
        stick_a = 1'b1;
        @(negedge clk);
        cfg_m2 = 11; cfg_timeout = 6; req_m2only = 1'b1;
        @(negedge clk);
        req_m2only = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 6) chk("R8", !err_timeout, err_timeout, 0);
            if (k == 7) chk("R8", err_timeout && pll_mode == 3'h4 && !busy, err_timeout, 1);
        end
        stick_a = 1'b0;
        idle(10);
        chk("R9", err_timeout, err_timeout, 1);
        start_full(90, 3, 6, 1'b1, 20);
        chk("R9", !err_timeout, err_timeout, 0);
        wait_end(cyc);
        chk("R4", done && pll_mode == 3'h7 && pll_mult == 90, pll_mult, 90);
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1'b0, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule